// File: doc/BRIEF.md
# Transmit buffer command controller

This block keeps the state of four transmit frame buffers and decides which buffer the protocol engine should send next. Each buffer has its own small state machine. Software drives it through a command word, and the protocol engine drives it through event strobes. A single software write carries one or more command bits together with a one-hot buffer selection. The command is applied to every selected buffer on the next clock edge. After that the command word clears itself, so software never writes zero to it.

The block offers for transmission the Ready buffer with the highest priority. A tie goes to the lower buffer index. While the engine owns a buffer, that buffer's outcome is reported by strobes: success, error, lost arbitration, or an abort of the whole transmission. A shared attempt counter can stop retries after a programmable number of attempts, and a buffer that runs out of attempts goes to a Failed state. A status output shows whether any buffer is free.

Top module: `txbuf_cmd_ctrl`

## Requirements
- R1: After reset the block is in this state. Every buffer state code is 0 (Empty). Every priority field is 0. The attempt counter is 0 and the command word reads 0. `buf_avail` is 1 and `offer_valid` is 0.
- R2: The command word has this layout: bit 0 is set ready, bit 1 is set empty, bit 2 is abort, and bits 3 to 6 select buffers 0 to 3, one bit each. A write is applied to every selected buffer on the clock edge after the write. `cmd_reg` shows the written value for that one cycle and then reads 0 by itself.
- R3: Set ready moves a buffer to Ready from Empty, TX OK, Failed, TX Error or Aborted. In TX in progress the command is ignored. The state codes are Empty=0, Ready=1, TX in progress=2, TX OK=3, Failed=4, TX Error=5 and Aborted=6.
- R4: Set empty moves a buffer to Empty from every state except TX in progress. In TX in progress it is ignored.
- R5: Abort moves a Ready or TX in progress buffer to Aborted, and leaves a buffer in any other state unchanged. When several command bits are set, only the strongest is used: abort first, then set empty, then set ready.
- R6: `offer_valid` and `offer_idx` name the Ready buffer with the largest priority, with ties going to the lower index. A `pe_start` pulse while no buffer is in TX in progress moves the offered buffer to TX in progress. At most one buffer is ever in TX in progress.
- R7: `pe_ok` moves the buffer in TX in progress to TX OK and clears the attempt counter.
- R8: `pe_err` or `pe_arb_lost` during a transmission adds 1 to the attempt counter, which saturates at its maximum. If the limit is off, the buffer returns to Ready. If the limit is on and the incremented count is at least `rtr_limit`, the buffer goes to Failed.
- R9: A start clears the attempt counter, except when the buffer being started is the same one that just returned to Ready through R8. In that case the count is kept.
- R10: `at_cmd` while `pe_is_tx` is 1 moves the buffer in TX in progress to TX Error, and drives `goto_idle` high for the next cycle. While `pe_is_tx` is 0, `at_cmd` changes nothing and `goto_idle` stays 0.
- R11: `buf_avail` is 1 exactly when at least one buffer is Empty.
- R12: `prio_we` loads all priority fields from `prio_wdata`. Buffer i uses bits [3i+2:3i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 7 | Command bits and one-hot buffer selection |
| prio_we | input | 1 | Priority register write strobe |
| prio_wdata | input | 12 | Priority fields, 3 bits per buffer |
| rtr_limit_en | input | 1 | Enables the attempt limit |
| rtr_limit | input | 4 | Maximum number of attempts |
| pe_is_tx | input | 1 | Protocol engine is currently transmitter |
| pe_start | input | 1 | Engine takes the offered buffer |
| pe_ok | input | 1 | Transmission succeeded |
| pe_err | input | 1 | Transmission error |
| pe_arb_lost | input | 1 | Arbitration lost |
| at_cmd | input | 1 | Abort-transmission command for the core |
| cmd_reg | output | 7 | Command word read-back |
| prio_q | output | 12 | Priority register read-back |
| buf_state | output | 12 | State code of each buffer, 3 bits per buffer |
| buf_avail | output | 1 | At least one buffer is Empty |
| offer_valid | output | 1 | A Ready buffer is offered |
| offer_idx | output | 2 | Index of the offered buffer |
| rtr_count | output | 4 | Attempt counter |
| goto_idle | output | 1 | Core must return to interframe |

## Verification
The hardest case to reach is the attempt limit. The bench first has to drive a buffer through several failed attempts. During those attempts the same buffer must stay the offered one, so that its count is kept under R9 and not cleared. Only then can the switch to Failed be checked. The stimulus arranges this with a priority setup in which buffer 1 ties with buffer 2, so the lower index wins each time. The bench then alternates start, error and lost-arbitration strobes, and enables the limit only just before the last attempt. A later case with a limit of one shows that a fresh buffer fails on its first error.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY   = 3'd0,
        ST_READY   = 3'd1,
        ST_TXPROG  = 3'd2,
        ST_TXOK    = 3'd3,
        ST_FAILED  = 3'd4,
        ST_TXERR   = 3'd5,
        ST_ABORTED = 3'd6
    } buf_state_t;

    localparam int CMD_RDY_BIT = 0;
    localparam int CMD_EMP_BIT = 1;
    localparam int CMD_ABT_BIT = 2;
    localparam int CMD_SEL_LSB = 3;
    localparam int STATE_W     = 3;

    function automatic logic ready_accepts(buf_state_t s);
        return (s != ST_TXPROG);
    endfunction

endpackage

// File: rtl/txbuf_slot.sv
module txbuf_slot
    import txbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_hit,
    input  logic       cmd_ready,
    input  logic       cmd_empty,
    input  logic       cmd_abort,
    input  logic       start,
    input  logic       ev_ok,
    input  logic       ev_txerr,
    input  logic       ev_fail,
    input  logic       ev_retry,
    output buf_state_t state
);

    buf_state_t nxt;

    always_comb begin
        nxt = state;
        if (state == ST_TXPROG) begin
            if (ev_ok)                      nxt = ST_TXOK;
            else if (ev_txerr)              nxt = ST_TXERR;
            else if (ev_fail)               nxt = ST_FAILED;
            else if (ev_retry)              nxt = ST_READY;
            else if (cmd_hit && cmd_abort)  nxt = ST_ABORTED;
        end else if (cmd_hit && cmd_abort) begin
            if (state == ST_READY)          nxt = ST_ABORTED;
        end else if (cmd_hit && cmd_empty) begin
            nxt = ST_EMPTY;
        end else if (cmd_hit && cmd_ready) begin
            if (ready_accepts(state))       nxt = ST_READY;
        end else if (start && state == ST_READY) begin
            nxt = ST_TXPROG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= nxt;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TXPROG && !ev_ok && !ev_txerr && !ev_fail && !ev_retry
         && !(cmd_hit && cmd_abort)) |=> state == ST_TXPROG); // R4
    AST_TX_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state != ST_TXPROG && !start) |=> state != ST_TXPROG); // R6

endmodule

// File: rtl/txbuf_arbiter.sv
module txbuf_arbiter #(
    parameter int NBUF = 4,
    parameter int PW   = 3,
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0]    ready_vec,
    input  logic [NBUF*PW-1:0] prio,
    output logic               valid,
    output logic [IW-1:0]      idx
);

    logic [PW-1:0] best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (ready_vec[i] && (!valid || prio[PW*i +: PW] > best)) begin
                valid = 1'b1;
                idx   = IW'(i);
                best  = prio[PW*i +: PW];
            end
        end
    end

endmodule

// File: rtl/txbuf_retry.sv
module txbuf_retry #(
    parameter int RW = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] start_idx,
    input  logic          ev_ok,
    input  logic          ev_again,
    input  logic          ev_abort,
    input  logic          lim_en,
    input  logic [RW-1:0] lim,
    output logic [RW-1:0] cnt,
    output logic          lim_hit
);

    logic [RW-1:0] cnt_inc;
    logic [IW-1:0] last_idx;
    logic          retrying;

    assign cnt_inc = (cnt == {RW{1'b1}}) ? cnt : cnt + 1'b1;
    assign lim_hit = lim_en && (cnt_inc >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            last_idx <= '0;
            retrying <= 1'b0;
        end else if (start) begin
            if (!(retrying && start_idx == last_idx)) cnt <= '0;
            last_idx <= start_idx;
            retrying <= 1'b0;
        end else if (ev_ok) begin
            cnt      <= '0;
            retrying <= 1'b0;
        end else if (ev_again) begin
            cnt      <= cnt_inc;
            retrying <= !lim_hit;
        end else if (ev_abort) begin
            retrying <= 1'b0;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1)); // R8
    AST_CNT_OK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ev_ok && !start) |=> cnt == '0); // R7

endmodule

// File: rtl/txbuf_cmd_ctrl.sv
module txbuf_cmd_ctrl
    import txbuf_pkg::*;
#(
    parameter int NBUF = 4,
    parameter int PW   = 3,
    parameter int RW   = 4,
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int CW  = CMD_SEL_LSB + NBUF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_we,
    input  logic [CW-1:0]           cmd_wdata,
    input  logic                    prio_we,
    input  logic [NBUF*PW-1:0]      prio_wdata,
    input  logic                    rtr_limit_en,
    input  logic [RW-1:0]           rtr_limit,
    input  logic                    pe_is_tx,
    input  logic                    pe_start,
    input  logic                    pe_ok,
    input  logic                    pe_err,
    input  logic                    pe_arb_lost,
    input  logic                    at_cmd,
    output logic [CW-1:0]           cmd_reg,
    output logic [NBUF*PW-1:0]      prio_q,
    output logic [NBUF*STATE_W-1:0] buf_state,
    output logic                    buf_avail,
    output logic                    offer_valid,
    output logic [IW-1:0]           offer_idx,
    output logic [RW-1:0]           rtr_count,
    output logic                    goto_idle
);

    buf_state_t      st [NBUF];
    logic [NBUF-1:0] active_vec;
    logic [NBUF-1:0] ready_vec;
    logic [NBUF-1:0] empty_vec;
    logic            busy;
    logic            start_go;
    logic            bus_abort;
    logic            again;
    logic            lim_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_reg   <= '0;
            prio_q    <= '0;
            goto_idle <= 1'b0;
        end else begin
            cmd_reg   <= cmd_we ? cmd_wdata : '0;
            if (prio_we) prio_q <= prio_wdata;
            goto_idle <= at_cmd && pe_is_tx;
        end
    end

    assign busy      = |active_vec;
    assign start_go  = pe_start && !busy && offer_valid;
    assign bus_abort = busy && at_cmd && pe_is_tx && !pe_ok;
    assign again     = busy && (pe_err || pe_arb_lost) && !pe_ok && !bus_abort;
    assign buf_avail = |empty_vec;

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        txbuf_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .cmd_hit  (cmd_reg[CMD_SEL_LSB + i]),
            .cmd_ready(cmd_reg[CMD_RDY_BIT]),
            .cmd_empty(cmd_reg[CMD_EMP_BIT]),
            .cmd_abort(cmd_reg[CMD_ABT_BIT]),
            .start    (start_go && offer_idx == IW'(i)),
            .ev_ok    (active_vec[i] && pe_ok),
            .ev_txerr (active_vec[i] && bus_abort),
            .ev_fail  (active_vec[i] && again && lim_hit),
            .ev_retry (active_vec[i] && again && !lim_hit),
            .state    (st[i])
        );
        assign active_vec[i] = (st[i] == ST_TXPROG);
        assign ready_vec[i]  = (st[i] == ST_READY);
        assign empty_vec[i]  = (st[i] == ST_EMPTY);
        assign buf_state[STATE_W*i +: STATE_W] = st[i];
    end

    txbuf_arbiter #(.NBUF(NBUF), .PW(PW)) u_arb (
        .ready_vec(ready_vec),
        .prio     (prio_q),
        .valid    (offer_valid),
        .idx      (offer_idx)
    );

    txbuf_retry #(.RW(RW), .IW(IW)) u_retry (
        .clk      (clk),
        .rst      (rst),
        .start    (start_go),
        .start_idx(offer_idx),
        .ev_ok    (busy && pe_ok),
        .ev_again (again),
        .ev_abort (bus_abort),
        .lim_en   (rtr_limit_en),
        .lim      (rtr_limit),
        .cnt      (rtr_count),
        .lim_hit  (lim_hit)
    );

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active_vec)); // R6
    AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_reg != '0 && !cmd_we) |=> cmd_reg == '0); // R2
    AST_OFFER_READY: assert property (@(posedge clk) disable iff (rst)
        offer_valid |-> st[offer_idx] == ST_READY); // R6
    AST_IDLE_ONLY_TX: assert property (@(posedge clk) disable iff (rst)
        goto_idle |-> $past(pe_is_tx)); // R10

endmodule

// File: tb/txbuf_cmd_ctrl_tb_top.sv
module txbuf_cmd_ctrl_tb_top;

    localparam int E = 0, R = 1, P = 2, OK = 3, F = 4, TE = 5, AB = 6;
    localparam int K_STATE = 0, K_CNT = 1, K_AVAIL = 2, K_OFFER = 3,
                   K_CMD = 4, K_PRIO = 5, K_IDLE = 6;

    typedef struct {
        int    kind;
        string req;
        int    exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [6:0]  cmd_wdata = '0;
    logic        prio_we = 1'b0;
    logic [11:0] prio_wdata = '0;
    logic        rtr_limit_en = 1'b0;
    logic [3:0]  rtr_limit = '0;
    logic        pe_is_tx = 1'b0;
    logic        pe_start = 1'b0, pe_ok = 1'b0, pe_err = 1'b0, pe_arb_lost = 1'b0;
    logic        at_cmd = 1'b0;
    logic [6:0]  cmd_reg;
    logic [11:0] prio_q;
    logic [11:0] buf_state;
    logic        buf_avail, offer_valid, goto_idle;
    logic [1:0]  offer_idx;
    logic [3:0]  rtr_count;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #4 clk = ~clk;

    txbuf_cmd_ctrl dut_i (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .prio_we(prio_we), .prio_wdata(prio_wdata),
        .rtr_limit_en(rtr_limit_en), .rtr_limit(rtr_limit),
        .pe_is_tx(pe_is_tx), .pe_start(pe_start), .pe_ok(pe_ok),
        .pe_err(pe_err), .pe_arb_lost(pe_arb_lost), .at_cmd(at_cmd),
        .cmd_reg(cmd_reg), .prio_q(prio_q), .buf_state(buf_state),
        .buf_avail(buf_avail), .offer_valid(offer_valid),
        .offer_idx(offer_idx), .rtr_count(rtr_count), .goto_idle(goto_idle)
    );

    function automatic int pk(int s0, int s1, int s2, int s3);
        return s0 | (s1 << 3) | (s2 << 6) | (s3 << 9);
    endfunction

    function automatic int sample(int kind);
        case (kind)
            K_STATE: return int'(buf_state);
            K_CNT:   return int'(rtr_count);
            K_AVAIL: return int'(buf_avail);
            K_OFFER: return int'({offer_valid, offer_idx});
            K_CMD:   return int'(cmd_reg);
            K_PRIO:  return int'(prio_q);
            default: return int'(goto_idle);
        endcase
    endfunction

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int    act;
            it  = q.pop_front();
            act = sample(it.kind);
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s kind %0d actual %0h expected %0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_v(int kind, string req, int val);
        item_t it;
        it.kind = kind; it.req = req; it.exp = val;
        q.push_back(it);
    endtask

    task automatic expect_all(string req, int st, int cnt, int avail, int offer);
        expect_v(K_STATE, req, st);
        expect_v(K_CNT, req, cnt);
        expect_v(K_AVAIL, req, avail);
        expect_v(K_OFFER, req, offer);
    endtask

    // bits: 1 set ready, 2 set empty, 4 abort; sel one-hot buffers 0..3
    task automatic send_cmd(int bits, int sel);
        @(posedge clk); #1;
        cmd_we = 1'b1; cmd_wdata = 7'((sel << 3) | bits);
        @(posedge clk); #1;
        cmd_we = 1'b0;
        expect_v(K_CMD, "R2", (sel << 3) | bits);
        @(posedge clk); #1;
        expect_v(K_CMD, "R2", 0);
    endtask

    // 0 start, 1 ok, 2 err, 3 arb lost, 4 core abort
    task automatic pulse(int which);
        @(posedge clk); #1;
        case (which)
            0: pe_start = 1'b1;
            1: pe_ok = 1'b1;
            2: pe_err = 1'b1;
            3: pe_arb_lost = 1'b1;
            default: at_cmd = 1'b1;
        endcase
        @(posedge clk); #1;
        pe_start = 1'b0; pe_ok = 1'b0; pe_err = 1'b0; pe_arb_lost = 1'b0; at_cmd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_all("R1", pk(E, E, E, E), 0, 1, 0);
        expect_v(K_PRIO, "R1", 0);
        expect_v(K_CMD, "R1", 0);

        // R12: priorities b0=1 b1=3 b2=3 b3=2
        @(posedge clk); #1;
        prio_we = 1'b1; prio_wdata = 12'(1 | (3 << 3) | (3 << 6) | (2 << 9));
        @(posedge clk); #1;
        prio_we = 1'b0;
        expect_v(K_PRIO, "R12", 1241);

        // R3 R11 R6: ready on 0..2, tie b1/b2 -> b1
        send_cmd(1, 4'b0111);
        expect_all("R3_R11_R6", pk(R, R, R, E), 0, 1, 4 | 1);
        send_cmd(1, 4'b1000);
        expect_all("R11", pk(R, R, R, R), 0, 0, 4 | 1);

        pulse(0);
        expect_all("R6", pk(R, P, R, R), 0, 0, 4 | 2);

        // R4 R3: refused while in progress
        send_cmd(2, 4'b0010);
        expect_v(K_STATE, "R4", pk(R, P, R, R));
        send_cmd(1, 4'b0010);
        expect_v(K_STATE, "R3", pk(R, P, R, R));

        // R8 R9: retries keep the count on the same buffer
        pulse(2);
        expect_all("R8", pk(R, R, R, R), 1, 0, 4 | 1);
        pulse(0);
        expect_all("R9", pk(R, P, R, R), 1, 0, 4 | 2);
        pulse(3);
        expect_all("R8", pk(R, R, R, R), 2, 0, 4 | 1);
        rtr_limit_en = 1'b1; rtr_limit = 4'd3;
        pulse(0);
        expect_v(K_CNT, "R9", 2);
        pulse(2);
        expect_all("R8", pk(R, F, R, R), 3, 0, 4 | 2);

        // R9 R7: new buffer clears, success clears
        pulse(0);
        expect_all("R9", pk(R, F, P, R), 0, 0, 4 | 3);
        pulse(2);
        expect_all("R8", pk(R, F, R, R), 1, 0, 4 | 2);
        pulse(0);
        expect_v(K_CNT, "R9", 1);
        pulse(1);
        expect_all("R7", pk(R, F, OK, R), 0, 0, 4 | 3);

        // R10: core abort as transmitter
        pulse(0);
        expect_v(K_STATE, "R6", pk(R, F, OK, P));
        pe_is_tx = 1'b1;
        pulse(4);
        expect_v(K_IDLE, "R10", 1);
        expect_all("R10", pk(R, F, OK, TE), 0, 0, 4 | 0);

        // R10: core abort as receiver only
        pulse(0);
        pe_is_tx = 1'b0;
        pulse(4);
        expect_v(K_IDLE, "R10", 0);
        expect_v(K_STATE, "R10", pk(P, F, OK, TE));

        // R5: abort on in-progress b0 and TX OK b2
        send_cmd(4, 4'b0101);
        expect_all("R5", pk(AB, F, OK, TE), 0, 0, 0);

        // R3: ready from Aborted, Failed, TX Error, TX OK
        send_cmd(1, 4'b1011);
        expect_v(K_STATE, "R3", pk(R, R, OK, R));
        send_cmd(1, 4'b0100);
        expect_v(K_STATE, "R3", pk(R, R, R, R));

        // R5 R4: empty beats ready
        send_cmd(3, 4'b1111);
        expect_all("R5_R4", pk(E, E, E, E), 0, 1, 0);
        // R5: abort beats ready, abort ignored on Empty
        send_cmd(5, 4'b0001);
        expect_v(K_STATE, "R5", pk(E, E, E, E));

        // R8: limit of one attempt
        rtr_limit = 4'd1;
        send_cmd(1, 4'b0001);
        pulse(0);
        expect_v(K_CNT, "R9", 0);
        pulse(3);
        expect_all("R8", pk(F, E, E, E), 1, 1, 0);

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule